// File: doc/BRIEF.md
# Shifter Operand Generator

This block forms the second source operand of a 32-bit data-processing or load/store instruction, together with the carry-out of the shifter. It is purely combinational. The instruction word picks one of two forms. In the immediate form an 8-bit constant is rotated right by an even amount. In the register form a source register is shifted by one of four shift kinds. The amount for that shift comes either from a 5-bit field of the instruction or from the low byte of a second register.

The block does not read the register file itself. It presents the two register indices it needs, and the surrounding pipeline returns the two read values on the data inputs in the same cycle. The shifter carry-out goes to the flag logic for logical operations that set flags. One bit pattern in the register form does not describe a shifter operand, and the block flags it as illegal so that decode can raise an undefined-instruction trap.

Top module: `shifter_operand_gen`

## Requirements
- R1: With instruction bit 25 set, the operand is the zero-extended constant in bits 7:0, rotated right by twice the unsigned value of bits 11:8.
- R2: In the immediate form the carry-out equals the incoming carry when bits 11:8 are zero, and otherwise equals bit 31 of the operand.
- R3: With bit 25 clear and bit 4 clear, the register read at index bits 3:0 is shifted by the amount in bits 11:7. The kind comes from bits 6:5: 0 is logical left, 1 is logical right, 2 is arithmetic right and 3 is rotate right. The carry-out is the last bit shifted out.
- R4: With bit 25 clear and bit 4 set, the shift amount is bits 7:0 of the register read at index bits 11:8. Bits 31:8 of that register have no effect.
- R5: For register amounts of 32 or more, a logical shift gives zero. The carry-out is then bit 0 (left) or bit 31 (right) of the source when the amount is exactly 32, and zero for larger amounts. An arithmetic right shift gives 32 copies of source bit 31, with that bit as carry-out.
- R6: A rotate by a nonzero register amount rotates by the amount modulo 32. When the amount is a nonzero multiple of 32, the value is unchanged and the carry-out is source bit 31.
- R7: A register-form shift amount of zero, of any kind, passes the source through unchanged with the incoming carry as carry-out.
- R8: The illegal flag is 1 exactly when bit 25 is clear and bits 4 and 7 are both set. The operand is then zero and the carry-out is the incoming carry. The immediate form never raises the flag.
- R9: The source index output always equals bits 3:0 and the amount-register index output always equals bits 11:8.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word |
| rm_data_i | input | 32 | Value read at the source index |
| rs_data_i | input | 32 | Value read at the amount-register index |
| carry_i | input | 1 | Current carry flag |
| rm_idx_o | output | 4 | Source register index |
| rs_idx_o | output | 4 | Amount register index |
| operand_o | output | 32 | Generated operand |
| carry_o | output | 1 | Shifter carry-out |
| illegal_o | output | 1 | Encoding is not a shifter operand |

## Verification
Illegal-pattern detection and the immediate rotate look at the same instruction bits 4 and 7. In the immediate form those bits belong to the constant, so they must reach the operand and must not raise the flag. The bench provokes this overlap with a constant that has both bits set, under a nonzero rotation. It expects the rotated constant, the illegal flag low, and bit 31 of the result as carry. The same bit pair is then applied in the register form, where the bench expects a zero operand, the incoming carry passed through, and the flag raised.

// File: rtl/shop_pkg.sv
package shop_pkg;
  typedef enum logic [1:0] {
    SH_LSL = 2'd0,
    SH_LSR = 2'd1,
    SH_ASR = 2'd2,
    SH_ROR = 2'd3
  } shift_kind_e;

  localparam int IMM_FORM_BIT = 25;
  localparam int REG_AMT_BIT  = 4;
  localparam int CLASH_BIT    = 7;
endpackage

// File: rtl/shop_decode.sv
module shop_decode
  import shop_pkg::*;
#(
  parameter int INSTR_W = 32,
  parameter int IDX_W   = 4,
  parameter int IMM_W   = 8,
  parameter int ROT_W   = 4,
  parameter int SHAMT_W = 5
) (
  input  logic [INSTR_W-1:0] instr,
  output logic               is_imm,
  output logic               use_reg_amt,
  output logic               illegal,
  output shift_kind_e        kind,
  output logic [SHAMT_W-1:0] imm_amt,
  output logic [IMM_W-1:0]   imm_const,
  output logic [ROT_W-1:0]   imm_rot,
  output logic [IDX_W-1:0]   src_idx,
  output logic [IDX_W-1:0]   amt_idx
);
  localparam int AMT_IDX_LO = 8;
  localparam int SHAMT_LO   = 7;
  localparam int KIND_LO    = 5;

  logic unused_instr_hi;

  assign is_imm      = instr[IMM_FORM_BIT];
  assign use_reg_amt = instr[REG_AMT_BIT];
  assign illegal     = !instr[IMM_FORM_BIT] && instr[REG_AMT_BIT] && instr[CLASH_BIT];
  assign kind        = shift_kind_e'(instr[KIND_LO +: 2]);
  assign imm_amt     = instr[SHAMT_LO +: SHAMT_W];
  assign imm_const   = instr[IMM_W-1:0];
  assign imm_rot     = instr[AMT_IDX_LO +: ROT_W];
  assign src_idx     = instr[IDX_W-1:0];
  assign amt_idx     = instr[AMT_IDX_LO +: IDX_W];

  assign unused_instr_hi = ^{instr[INSTR_W-1:IMM_FORM_BIT+1],
                             instr[IMM_FORM_BIT-1:AMT_IDX_LO+IDX_W]};
endmodule

// File: rtl/shop_barrel.sv
module shop_barrel
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] val,
  input  shift_kind_e       kind,
  input  logic [AMT_W-1:0]  amt,
  input  logic              cin,
  output logic [DATA_W-1:0] res,
  output logic              cout
);
  localparam int SH_W = $clog2(DATA_W);

  logic [SH_W-1:0]          low;
  logic                     zero_amt;
  logic                     wide;
  logic                     exact;
  logic [DATA_W:0]          ext_l;
  logic [DATA_W:0]          ext_r;
  logic signed [DATA_W:0]   ext_a;
  logic [DATA_W-1:0]        rot;

  assign low      = amt[SH_W-1:0];
  assign zero_amt = (amt == '0);
  assign wide     = (amt >= AMT_W'(DATA_W));
  assign exact    = (amt == AMT_W'(DATA_W));

  assign ext_l = {1'b0, val} << low;
  assign ext_r = {val, 1'b0} >> low;
  assign ext_a = $signed({val, 1'b0}) >>> low;
  assign rot   = (val >> low) | (val << (DATA_W - int'(low)));

  always_comb begin
    res  = val;
    cout = cin;
    if (!zero_amt) begin
      unique case (kind)
        SH_LSL: begin
          if (wide) begin
            res  = '0;
            cout = exact ? val[0] : 1'b0;
          end else begin
            res  = ext_l[DATA_W-1:0];
            cout = ext_l[DATA_W];
          end
        end
        SH_LSR: begin
          if (wide) begin
            res  = '0;
            cout = exact ? val[DATA_W-1] : 1'b0;
          end else begin
            res  = ext_r[DATA_W:1];
            cout = ext_r[0];
          end
        end
        SH_ASR: begin
          if (wide) begin
            res  = {DATA_W{val[DATA_W-1]}};
            cout = val[DATA_W-1];
          end else begin
            res  = ext_a[DATA_W:1];
            cout = ext_a[0];
          end
        end
        SH_ROR: begin
          res  = rot;
          cout = rot[DATA_W-1];
        end
        default: begin
          res  = val;
          cout = cin;
        end
      endcase
    end
  end
endmodule

// File: rtl/shifter_operand_gen.sv
module shifter_operand_gen
  import shop_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 4,
  parameter int IMM_W  = 8,
  parameter int ROT_W  = 4,
  parameter int AMT_W  = 8
) (
  input  logic [DATA_W-1:0] instr_i,
  input  logic [DATA_W-1:0] rm_data_i,
  input  logic [DATA_W-1:0] rs_data_i,
  input  logic              carry_i,
  output logic [IDX_W-1:0]  rm_idx_o,
  output logic [IDX_W-1:0]  rs_idx_o,
  output logic [DATA_W-1:0] operand_o,
  output logic              carry_o,
  output logic              illegal_o
);
  localparam int SHAMT_W = $clog2(DATA_W);

  logic               is_imm;
  logic               use_reg_amt;
  logic               illegal;
  shift_kind_e        kind;
  logic [SHAMT_W-1:0] imm_amt;
  logic [IMM_W-1:0]   imm_const;
  logic [ROT_W-1:0]   imm_rot;

  logic [DATA_W-1:0]  imm_val;
  logic [AMT_W-1:0]   imm_rot_amt;
  logic [DATA_W-1:0]  imm_res;
  logic               imm_cout;

  logic [AMT_W-1:0]   reg_amt;
  logic [DATA_W-1:0]  reg_res;
  logic               reg_cout;
  logic               unused_rs_hi;

  shop_decode #(
    .INSTR_W(DATA_W), .IDX_W(IDX_W), .IMM_W(IMM_W),
    .ROT_W(ROT_W), .SHAMT_W(SHAMT_W)
  ) u_decode (
    .instr      (instr_i),
    .is_imm     (is_imm),
    .use_reg_amt(use_reg_amt),
    .illegal    (illegal),
    .kind       (kind),
    .imm_amt    (imm_amt),
    .imm_const  (imm_const),
    .imm_rot    (imm_rot),
    .src_idx    (rm_idx_o),
    .amt_idx    (rs_idx_o)
  );

  assign imm_val     = {{(DATA_W-IMM_W){1'b0}}, imm_const};
  assign imm_rot_amt = {{(AMT_W-ROT_W-1){1'b0}}, imm_rot, 1'b0};

  shop_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_imm_rot (
    .val (imm_val),
    .kind(SH_ROR),
    .amt (imm_rot_amt),
    .cin (carry_i),
    .res (imm_res),
    .cout(imm_cout)
  );

  assign reg_amt = use_reg_amt ? rs_data_i[AMT_W-1:0]
                               : {{(AMT_W-SHAMT_W){1'b0}}, imm_amt};

  shop_barrel #(.DATA_W(DATA_W), .AMT_W(AMT_W)) u_reg_shift (
    .val (rm_data_i),
    .kind(kind),
    .amt (reg_amt),
    .cin (carry_i),
    .res (reg_res),
    .cout(reg_cout)
  );

  assign unused_rs_hi = ^rs_data_i[DATA_W-1:AMT_W];

  always_comb begin
    illegal_o = illegal;
    if (is_imm) begin
      operand_o = imm_res;
      carry_o   = imm_cout;
    end else if (illegal) begin
      operand_o = '0;
      carry_o   = carry_i;
    end else begin
      operand_o = reg_res;
      carry_o   = reg_cout;
    end
  end
endmodule

// File: rtl/shop_checker.sv
module shop_checker #(
  parameter int DATA_W = 32
) (
  input logic [DATA_W-1:0] instr_i,
  input logic [DATA_W-1:0] rm_data_i,
  input logic [DATA_W-1:0] rs_data_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] operand_o,
  input logic              carry_o,
  input logic              illegal_o
);
  logic       legal_reg;
  logic [7:0] amt_eff;
  logic       unused_chk;

  assign legal_reg  = !instr_i[25] && !(instr_i[4] && instr_i[7]);
  assign amt_eff    = instr_i[4] ? rs_data_i[7:0] : {3'b000, instr_i[11:7]};
  assign unused_chk = ^{instr_i[31:26], instr_i[24:12], instr_i[3:0], rs_data_i[DATA_W-1:8]};

  always_comb begin
    if (instr_i[25]) begin
      AST_IMM_BITS_KEPT: assert ($countones(operand_o) == $countones(instr_i[7:0]) && !illegal_o)
        else $error("immediate rotate lost bits"); // R1
      if (instr_i[11:8] == 4'd0) begin
        AST_IMM_ZERO_ROT: assert (operand_o == {24'd0, instr_i[7:0]} && carry_o == carry_i)
          else $error("zero rotation altered value or carry"); // R2
      end
    end
    if (legal_reg && instr_i[6:5] == 2'd3) begin
      AST_ROR_BITS_KEPT: assert ($countones(operand_o) == $countones(rm_data_i))
        else $error("rotate lost bits"); // R6
    end
    if (legal_reg && amt_eff == 8'd0) begin
      AST_ZERO_AMT_PASS: assert (operand_o == rm_data_i && carry_o == carry_i)
        else $error("zero amount altered source"); // R7
    end
    if (legal_reg && instr_i[6] == 1'b0 && amt_eff > 8'd32) begin
      AST_WIDE_LOGICAL_ZERO: assert (operand_o == '0 && !carry_o)
        else $error("wide logical shift not cleared"); // R5
    end
    if (legal_reg && instr_i[6:5] == 2'd2 && amt_eff >= 8'd32) begin
      AST_WIDE_ARITH_FILL: assert (operand_o == {DATA_W{rm_data_i[DATA_W-1]}} && carry_o == rm_data_i[DATA_W-1])
        else $error("wide arithmetic shift not sign filled"); // R5
    end
    if (illegal_o) begin
      AST_ILLEGAL_QUIET: assert (operand_o == '0 && carry_o == carry_i && !instr_i[25])
        else $error("illegal encoding produced an operand"); // R8
    end
  end
endmodule

bind shifter_operand_gen shop_checker #(.DATA_W(DATA_W)) u_shop_checker (
  .instr_i  (instr_i),
  .rm_data_i(rm_data_i),
  .rs_data_i(rs_data_i),
  .carry_i  (carry_i),
  .operand_o(operand_o),
  .carry_o  (carry_o),
  .illegal_o(illegal_o)
);

// File: tb/shifter_operand_gen_bench.sv
module shifter_operand_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 100000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] instr, rm_data, rs_data;
  logic        cin;
  logic [3:0]  rm_idx, rs_idx;
  logic [31:0] operand;
  logic        cout, illegal;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  shifter_operand_gen u_shifter_operand_gen (
    .instr_i  (instr),
    .rm_data_i(rm_data),
    .rs_data_i(rs_data),
    .carry_i  (cin),
    .rm_idx_o (rm_idx),
    .rs_idx_o (rs_idx),
    .operand_o(operand),
    .carry_o  (cout),
    .illegal_o(illegal)
  );

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > WATCHDOG) begin
      fails = fails + 1;
      $display("FAIL watchdog (all): actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  function automatic void model(input logic [31:0] ins, input logic [31:0] rm,
                                input logic [31:0] rs, input logic ci,
                                output logic [31:0] op, output logic co,
                                output logic ill);
    logic [31:0] v;
    int          n;
    logic [1:0]  k;
    ill = !ins[25] && ins[4] && ins[7];
    co  = ci;
    if (ill) begin
      op = 32'd0;
      return;
    end
    if (ins[25]) begin
      v = {24'd0, ins[7:0]};
      n = 2 * int'(ins[11:8]);
      k = 2'd3;
    end else begin
      v = rm;
      n = ins[4] ? int'(rs[7:0]) : int'(ins[11:7]);
      k = ins[6:5];
    end
    for (int i = 0; i < n; i++) begin
      case (k)
        2'd0: begin co = v[31]; v = {v[30:0], 1'b0}; end
        2'd1: begin co = v[0];  v = {1'b0, v[31:1]}; end
        2'd2: begin co = v[0];  v = {v[31], v[31:1]}; end
        default: begin co = v[0]; v = {v[0], v[31:1]}; end
      endcase
    end
    op = v;
  endfunction

  function automatic logic [31:0] imm_ins(input logic [3:0] r, input logic [7:0] c);
    return {4'hE, 3'b001, 13'd0, r, c};
  endfunction

  function automatic logic [31:0] sh_imm(input logic [1:0] k, input logic [4:0] a);
    return {4'hE, 16'd0, a, k, 1'b0, 4'd2};
  endfunction

  function automatic logic [31:0] sh_reg(input logic [1:0] k);
    return {4'hE, 16'd0, 4'd5, 1'b0, k, 1'b1, 4'd3};
  endfunction

  task automatic run(input string tag, input logic [31:0] ins, input logic [31:0] rm,
                     input logic [31:0] rs, input logic ci);
    logic [31:0] e_op;
    logic        e_co, e_ill;
    @(posedge clk);
    #1;
    instr = ins; rm_data = rm; rs_data = rs; cin = ci;
    @(negedge clk);
    model(ins, rm, rs, ci, e_op, e_co, e_ill);
    checks = checks + 1;
    if (operand !== e_op || cout !== e_co || illegal !== e_ill) begin
      fails = fails + 1;
      $display("FAIL %s instr=%h: actual op=%h c=%b ill=%b expected op=%h c=%b ill=%b",
               tag, ins, operand, cout, illegal, e_op, e_co, e_ill);
    end
  endtask

  task automatic t_reset_state;
    run("R7", 32'd0, 32'd0, 32'd0, 1'b0);
  endtask

  task automatic t_imm_form;
    run("R2", imm_ins(4'd0, 8'hAB), 32'h0, 32'h0, 1'b1);
    run("R1", imm_ins(4'd4, 8'hFF), 32'h0, 32'h0, 1'b0);
    run("R2", imm_ins(4'd1, 8'h01), 32'h0, 32'h0, 1'b1);
    run("R1", imm_ins(4'd15, 8'h90), 32'h0, 32'h0, 1'b0);
    run("R8", imm_ins(4'd3, 8'h93), 32'h0, 32'h0, 1'b1);
  endtask

  task automatic t_imm_amount;
    run("R3", sh_imm(2'd0, 5'd4),  32'h8000000F, 32'h0, 1'b0);
    run("R3", sh_imm(2'd1, 5'd1),  32'h00000003, 32'h0, 1'b0);
    run("R3", sh_imm(2'd2, 5'd31), 32'h80000000, 32'h0, 1'b0);
    run("R3", sh_imm(2'd3, 5'd8),  32'h123456F0, 32'h0, 1'b0);
    run("R3", sh_imm(2'd2, 5'd4),  32'h7000000F, 32'h0, 1'b1);
  endtask

  task automatic t_reg_amount;
    run("R4", sh_reg(2'd0), 32'h0000F00F, 32'hFFFFFF04, 1'b0);
    run("R4", sh_reg(2'd1), 32'hDEADBEEF, 32'h00000100, 1'b1);
    run("R4", sh_reg(2'd2), 32'h80000010, 32'hABCDEF05, 1'b0);
  endtask

  task automatic t_wide;
    run("R5", sh_reg(2'd0), 32'h00000001, 32'd32,  1'b0);
    run("R5", sh_reg(2'd0), 32'hFFFFFFFF, 32'd33,  1'b1);
    run("R5", sh_reg(2'd1), 32'h80000000, 32'd32,  1'b0);
    run("R5", sh_reg(2'd1), 32'hFFFFFFFF, 32'd40,  1'b1);
    run("R5", sh_reg(2'd2), 32'h80000001, 32'd32,  1'b0);
    run("R5", sh_reg(2'd2), 32'h7FFFFFFF, 32'd200, 1'b1);
  endtask

  task automatic t_rotate_reg;
    run("R6", sh_reg(2'd3), 32'h80000001, 32'd32, 1'b0);
    run("R6", sh_reg(2'd3), 32'h0000000F, 32'd64, 1'b1);
    run("R6", sh_reg(2'd3), 32'h0000001C, 32'd36, 1'b0);
  endtask

  task automatic t_zero_amount;
    for (int k = 0; k < 4; k++) begin
      run("R7", sh_imm(2'(k), 5'd0), 32'hC0FFEE11, 32'h0, 1'b1);
    end
    run("R7", sh_reg(2'd3), 32'h12345678, 32'h00000000, 1'b1);
  endtask

  task automatic t_illegal;
    run("R8", sh_reg(2'd0) | 32'h80,      32'hFFFFFFFF, 32'd3, 1'b1);
    run("R8", sh_reg(2'd3) | 32'hF80,     32'h12345678, 32'd1, 1'b0);
    run("R8", sh_imm(2'd1, 5'd1) | 32'h10, 32'h00000003, 32'd0, 1'b0);
  endtask

  task automatic t_indices;
    logic [31:0] pats [4] = '{32'h00000000, 32'h00000F0F, 32'hFFFFFFFF, 32'h00000A35};
    for (int i = 0; i < 4; i++) begin
      @(posedge clk);
      #1;
      instr = pats[i];
      @(negedge clk);
      checks = checks + 1;
      if (rm_idx !== pats[i][3:0] || rs_idx !== pats[i][11:8]) begin
        fails = fails + 1;
        $display("FAIL R9 instr=%h: actual rm=%h rs=%h expected rm=%h rs=%h",
                 pats[i], rm_idx, rs_idx, pats[i][3:0], pats[i][11:8]);
      end
    end
  endtask

  initial begin
    instr = '0; rm_data = '0; rs_data = '0; cin = 1'b0;
    repeat (3) @(posedge clk);
    rst = 1'b0;
    t_reset_state();
    t_imm_form();
    t_imm_amount();
    t_reg_amount();
    t_wide();
    t_rotate_reg();
    t_zero_amount();
    t_illegal();
    t_indices();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule